// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block pairs a watchdog timer with two sticky status bits. Together they let firmware work out, after it restarts or resumes, why that happened. The watchdog counts a prescaled version of the system clock. A clear strobe from software restarts it. If the count reaches its terminal value first, the watchdog expires. In normal running, an expiry issues a one-cycle system reset. In the halted state it instead issues a one-cycle wake-up pulse and leaves halt.

The two bits are a time-out flag and a power-down flag, and their pair records the event that last mattered:

| Condition | Time-out flag | Power-down flag |
|---|---|---|
| Power-on or external reset pin | 0 | 0 |
| Reset pin pressed while halted | 0 | 1 |
| Watchdog expiry while running | 1 | unchanged |
| Watchdog expiry while halted | 1 | 1 |

Software entering halt raises a halt strobe, which sets the power-down flag. The clear strobe drops both flags. A power-on indication resets everything. The external reset pin is active low. It holds the system in reset for as long as it is low, and it restarts the watchdog.

Top module: `wdt_reset_cause`

## Requirements
- R1: While `por` is high, `sys_rst` is 1 and both flags are 0. After `por` falls, the watchdog counts from zero, so it first expires exactly 2^(PRESCALE_LOG2+COUNT_WIDTH) cycles after the release edge. With the defaults that is 64 cycles.
- R2: A `wdt_clr` strobe sampled with the reset pin high does three things: it drops `flag_to` to 0, drops `flag_pdf` to 0, and restarts the watchdog from zero.
- R3: When the watchdog expires while running:
  - it expires exactly 2^(PRESCALE_LOG2+COUNT_WIDTH) cycles after its last restart edge;
  - `flag_to` becomes 1 and `flag_pdf` keeps its value;
  - `sys_rst` is 1 for exactly one cycle, `wake` stays 0, and the watchdog restarts.
- R4: A `halt_req` strobe enters halt and sets `flag_pdf` to 1. It leaves `flag_to` and the watchdog count unchanged.
- R5: When the watchdog expires while halted, `flag_to` and `flag_pdf` both become 1. `wake` is 1 for exactly one cycle, `sys_rst` stays 0, and the block leaves halt.
- R6: While running, a low level on `ext_rst_n` gives `flag_to`=0 and `flag_pdf`=0. It keeps `sys_rst` at 1 in each cycle after a low sample. It also holds the watchdog at zero, so the next expiry comes exactly 2^(PRESCALE_LOG2+COUNT_WIDTH) cycles after the last low edge.
- R7: A low level on `ext_rst_n` that starts while halted leaves halt with `flag_to`=0 and `flag_pdf`=1. Both values hold for the whole time the pin stays low.
- R8: A `wdt_clr` strobe in the very cycle the watchdog would expire wins. No reset is issued, `flag_to` stays 0, and the full period starts over.
- R9: A `halt_req` strobe sampled while `ext_rst_n` is low is ignored. After the pin is released, `flag_pdf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on indication, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, sampled on the clock |
| halt_req | input | 1 | One-cycle strobe: software enters halt |
| wdt_clr | input | 1 | One-cycle strobe: software clears the watchdog |
| sys_rst | output | 1 | System reset, active high, registered |
| wake | output | 1 | One-cycle wake-up pulse from a watchdog expiry in halt |
| flag_to | output | 1 | Time-out flag |
| flag_pdf | output | 1 | Power-down flag |

## Verification
The watchdog is run to expiry from four different restart sources: a clear strobe, a reset-pin release, a previous expiry and power-on. Each run is sampled one cycle before and at the exact expiry cycle. This separates an off-by-one period from an expiry that never restarts. Expiries are provoked both while running and while halted, and with the power-down flag already set. This tells "unchanged" apart from "cleared" and tells wake apart from reset. The reset pin is pressed while halted, while running, and together with a halt strobe. This distinguishes the onset-latched power-down flag from one that follows the current state. A clear placed in the expiring cycle separates correct priority from a late clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_PIN_ONSET,
    EV_PIN_HOLD,
    EV_EXP_RUN,
    EV_EXP_HALT,
    EV_CLEAR,
    EV_HALT
  } wdt_event_e;

  typedef struct packed {
    logic to;
    logic pdf;
    logic halted;
  } cause_state_t;

  // Cycles from a restart edge to the edge that registers the expiry.
  function automatic int unsigned expiry_period(input int unsigned pre_log2,
                                                input int unsigned cnt_w);
    return 32'd1 << (pre_log2 + cnt_w);
  endfunction

  // Priority: reset pin, then software clear, then expiry, then halt entry.
  function automatic wdt_event_e classify(input logic pin_low,
                                          input logic pin_prev,
                                          input logic expire,
                                          input logic halted,
                                          input logic clr,
                                          input logic halt_req);
    if (pin_low)              return pin_prev ? EV_PIN_HOLD : EV_PIN_ONSET;
    if (clr)                  return EV_CLEAR;
    if (expire)               return halted ? EV_EXP_HALT : EV_EXP_RUN;
    if (halt_req && !halted)  return EV_HALT;
    return EV_IDLE;
  endfunction

  function automatic cause_state_t next_state(input wdt_event_e ev,
                                              input cause_state_t cur);
    cause_state_t nx;
    nx = cur;
    case (ev)
      EV_PIN_ONSET: begin
        nx.to     = 1'b0;
        nx.pdf    = cur.halted;   // pin pressed during halt keeps the mark
        nx.halted = 1'b0;
      end
      EV_PIN_HOLD: begin
        nx.to     = 1'b0;
        nx.halted = 1'b0;
      end
      EV_EXP_RUN: nx.to = 1'b1;
      EV_EXP_HALT: begin
        nx.to     = 1'b1;
        nx.pdf    = 1'b1;
        nx.halted = 1'b0;
      end
      EV_CLEAR: begin
        nx.to  = 1'b0;
        nx.pdf = 1'b0;
      end
      EV_HALT: begin
        nx.pdf    = 1'b1;
        nx.halted = 1'b1;
      end
      default: nx = cur;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned LOG2 = 2
) (
  input  logic clk,
  input  logic por,
  input  logic restart,
  output logic tick
);
  generate
    if (LOG2 == 0) begin : g_bypass
      assign tick = 1'b1;
    end else begin : g_divide
      localparam logic [LOG2-1:0] PRE_MAX = {LOG2{1'b1}};
      logic [LOG2-1:0] pre_q;

      always_ff @(posedge clk or posedge por) begin
        if (por)          pre_q <= '0;
        else if (restart) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
      end

      assign tick = (pre_q == PRE_MAX);
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic clk,
  input  logic por,
  input  logic tick,
  input  logic restart_req,
  output logic expire
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic             at_top;

  assign at_top = (cnt_q == CNT_MAX);
  assign expire = tick && at_top && !restart_req;

  always_ff @(posedge clk or posedge por) begin
    if (por)                       cnt_q <= '0;
    else if (restart_req || expire) cnt_q <= '0;
    else if (tick)                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_cause_flags.sv
module wdt_cause_flags
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       pin_low,
  input  logic       expire,
  input  logic       clr,
  input  logic       halt_req,
  output logic       flag_to,
  output logic       flag_pdf,
  output logic       halted,
  output logic       sys_rst,
  output logic       wake,
  output wdt_event_e ev
);
  cause_state_t st_q, st_d;
  logic         pin_prev_q;
  logic         rst_q, wake_q;

  assign ev   = classify(pin_low, pin_prev_q, expire, st_q.halted, clr, halt_req);
  assign st_d = next_state(ev, st_q);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      st_q       <= '0;
      pin_prev_q <= 1'b0;
      rst_q      <= 1'b1;
      wake_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      pin_prev_q <= pin_low;
      rst_q      <= pin_low || (ev == EV_EXP_RUN);
      wake_q     <= (ev == EV_EXP_HALT);
    end
  end

  assign flag_to  = st_q.to;
  assign flag_pdf = st_q.pdf;
  assign halted   = st_q.halted;
  assign sys_rst  = rst_q;
  assign wake     = wake_q;
endmodule

// File: rtl/wdt_reset_cause.sv
module wdt_reset_cause
  import wdt_pkg::*;
#(
  parameter int unsigned PRESCALE_LOG2 = 2,
  parameter int unsigned COUNT_WIDTH   = 4
) (
  input  logic clk,
  input  logic por,
  input  logic ext_rst_n,
  input  logic halt_req,
  input  logic wdt_clr,
  output logic sys_rst,
  output logic wake,
  output logic flag_to,
  output logic flag_pdf
);
  localparam int unsigned PERIOD = expiry_period(PRESCALE_LOG2, COUNT_WIDTH);

  logic       pin_low;
  logic       pre_tick;
  logic       cnt_restart;
  logic       pre_restart;
  logic       wdt_expire;
  logic       in_halt;
  wdt_event_e cause_ev;

  assign pin_low     = !ext_rst_n;
  assign cnt_restart = wdt_clr || pin_low;
  assign pre_restart = cnt_restart || wdt_expire;

  wdt_prescaler #(.LOG2(PRESCALE_LOG2)) u_pre (
    .clk     (clk),
    .por     (por),
    .restart (pre_restart),
    .tick    (pre_tick)
  );

  wdt_counter #(.WIDTH(COUNT_WIDTH)) u_cnt (
    .clk         (clk),
    .por         (por),
    .tick        (pre_tick),
    .restart_req (cnt_restart),
    .expire      (wdt_expire)
  );

  wdt_cause_flags u_flags (
    .clk      (clk),
    .por      (por),
    .pin_low  (pin_low),
    .expire   (wdt_expire),
    .clr      (wdt_clr),
    .halt_req (halt_req),
    .flag_to  (flag_to),
    .flag_pdf (flag_pdf),
    .halted   (in_halt),
    .sys_rst  (sys_rst),
    .wake     (wake),
    .ev       (cause_ev)
  );

  initial begin
    if (PERIOD < 2) $error("watchdog period too short");
  end
endmodule

// File: rtl/wdt_reset_cause_chk.sv
module wdt_reset_cause_chk
  import wdt_pkg::*;
(
  input logic       clk,
  input logic       por,
  input logic       ext_rst_n,
  input logic       halt_req,
  input logic       wdt_clr,
  input logic       sys_rst,
  input logic       wake,
  input logic       flag_to,
  input logic       flag_pdf,
  input logic       wdt_expire,
  input logic       in_halt,
  input wdt_event_e cause_ev
);
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (por)
    (wdt_clr && ext_rst_n) |=> (!flag_to && !flag_pdf)); // R2

  AST_RUN_EXPIRY: assert property (@(posedge clk) disable iff (por)
    (wdt_expire && !in_halt) |=> (sys_rst && flag_to && !wake)); // R3

  AST_RUN_PDF_KEPT: assert property (@(posedge clk) disable iff (por)
    (wdt_expire && !in_halt) |=> $stable(flag_pdf)); // R3

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (por)
    (halt_req && ext_rst_n && !wdt_clr && !wdt_expire) |=> flag_pdf); // R4

  AST_HALT_EXPIRY: assert property (@(posedge clk) disable iff (por)
    (wdt_expire && in_halt) |=> (wake && flag_to && flag_pdf && !sys_rst)); // R5

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (por)
    wake |=> !wake); // R5

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (por)
    !ext_rst_n |=> (sys_rst && !flag_to && !wake)); // R6

  AST_PIN_HALTED: assert property (@(posedge clk) disable iff (por)
    (!ext_rst_n && in_halt) |=> flag_pdf); // R7

  AST_PIN_NO_HALT: assert property (@(posedge clk) disable iff (por)
    (!ext_rst_n && !in_halt) |=> !in_halt); // R9

  AST_EVENT_LEGAL: assert property (@(posedge clk) disable iff (por)
    (cause_ev == EV_EXP_RUN) |-> ext_rst_n); // R6
endmodule

bind wdt_reset_cause wdt_reset_cause_chk u_chk (
  .clk        (clk),
  .por        (por),
  .ext_rst_n  (ext_rst_n),
  .halt_req   (halt_req),
  .wdt_clr    (wdt_clr),
  .sys_rst    (sys_rst),
  .wake       (wake),
  .flag_to    (flag_to),
  .flag_pdf   (flag_pdf),
  .wdt_expire (wdt_expire),
  .in_halt    (in_halt),
  .cause_ev   (cause_ev)
);

// File: tb/wdt_reset_cause_test.sv
`timescale 1ns/1ps
module wdt_reset_cause_test;
  localparam int PL2 = 2;
  localparam int CW  = 4;
  localparam int PER = 2 ** (PL2 + CW);   // 64 cycles per watchdog period

  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_CLR  = 2'd1;
  localparam logic [1:0] OP_HALT = 2'd2;
  localparam logic [1:0] OP_PIN  = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] n;
    logic       to;
    logic       pdf;
    logic       rst;
    logic       wk;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{OP_CLR,  8'd0,       1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 clear
    '{OP_IDLE, 8'(PER-1),  1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 not yet
    '{OP_IDLE, 8'd1,       1'b1,1'b0,1'b1,1'b0, 4'd3}, // R3 expiry
    '{OP_IDLE, 8'd1,       1'b1,1'b0,1'b0,1'b0, 4'd3}, // R3 one cycle
    '{OP_CLR,  8'd0,       1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2
    '{OP_HALT, 8'd0,       1'b0,1'b1,1'b0,1'b0, 4'd4}, // R4
    '{OP_IDLE, 8'(PER-3),  1'b0,1'b1,1'b0,1'b0, 4'd5}, // R5 not yet
    '{OP_IDLE, 8'd1,       1'b1,1'b1,1'b0,1'b1, 4'd5}, // R5 wake
    '{OP_IDLE, 8'd1,       1'b1,1'b1,1'b0,1'b0, 4'd5}, // R5 one cycle
    '{OP_IDLE, 8'(PER-2),  1'b1,1'b1,1'b0,1'b0, 4'd3}, // R3 not yet
    '{OP_IDLE, 8'd1,       1'b1,1'b1,1'b1,1'b0, 4'd3}, // R3 pdf kept
    '{OP_CLR,  8'd0,       1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2
    '{OP_HALT, 8'd0,       1'b0,1'b1,1'b0,1'b0, 4'd4}, // R4
    '{OP_PIN,  8'd3,       1'b0,1'b1,1'b1,1'b0, 4'd7}, // R7 pin in halt
    '{OP_IDLE, 8'd1,       1'b0,1'b1,1'b0,1'b0, 4'd7}, // R7
    '{OP_PIN,  8'd3,       1'b0,1'b0,1'b1,1'b0, 4'd6}, // R6 pin running
    '{OP_IDLE, 8'(PER-1),  1'b0,1'b0,1'b0,1'b0, 4'd6}, // R6 not yet
    '{OP_IDLE, 8'd1,       1'b1,1'b0,1'b1,1'b0, 4'd6}, // R6 restart timing
    '{OP_CLR,  8'd0,       1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2
    '{OP_IDLE, 8'(PER-2),  1'b0,1'b0,1'b0,1'b0, 4'd8}, // R8 setup
    '{OP_CLR,  8'd0,       1'b0,1'b0,1'b0,1'b0, 4'd8}, // R8 clear wins
    '{OP_IDLE, 8'(PER-1),  1'b0,1'b0,1'b0,1'b0, 4'd8}, // R8 not yet
    '{OP_IDLE, 8'd1,       1'b1,1'b0,1'b1,1'b0, 4'd8}  // R8 full period
  };

  logic clk = 1'b0;
  logic por = 1'b1;
  logic ext_rst_n = 1'b1;
  logic halt_req = 1'b0;
  logic wdt_clr = 1'b0;
  logic sys_rst, wake, flag_to, flag_pdf;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  wdt_reset_cause #(.PRESCALE_LOG2(PL2), .COUNT_WIDTH(CW)) uut (
    .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .halt_req(halt_req),
    .wdt_clr(wdt_clr), .sys_rst(sys_rst), .wake(wake),
    .flag_to(flag_to), .flag_pdf(flag_pdf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string what, input int req, input logic act, input logic exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int req, input logic to, input logic pdf,
                           input logic rst, input logic wk);
    check("flag_to",  req, flag_to,  to);
    check("flag_pdf", req, flag_pdf, pdf);
    check("sys_rst",  req, sys_rst,  rst);
    check("wake",     req, wake,     wk);
  endtask

  task automatic do_op(input logic [1:0] op, input int n);
    case (op)
      OP_CLR:  begin @(negedge clk); wdt_clr = 1'b1; @(negedge clk); wdt_clr = 1'b0; end
      OP_HALT: begin @(negedge clk); halt_req = 1'b1; @(negedge clk); halt_req = 1'b0; end
      OP_PIN:  begin
        @(negedge clk); ext_rst_n = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
        ext_rst_n = 1'b1;
      end
      default: for (int i = 0; i < n; i++) @(negedge clk);
    endcase
  endtask

  initial begin
    // R1: state while power-on is held
    repeat (3) @(negedge clk);
    check_all(1, 1'b0, 1'b0, 1'b1, 1'b0);
    por = 1'b0;

    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v].op, int'(VEC[v].n));
      check_all(int'(VEC[v].req), VEC[v].to, VEC[v].pdf, VEC[v].rst, VEC[v].wk);
    end

    // R9: halt strobe while the pin is low is ignored
    @(negedge clk); ext_rst_n = 1'b0;
    @(negedge clk); halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
    @(negedge clk); ext_rst_n = 1'b1;
    check_all(9, 1'b0, 1'b0, 1'b1, 1'b0);
    do_op(OP_IDLE, 1);
    check_all(9, 1'b0, 1'b0, 1'b0, 1'b0);
    do_op(OP_IDLE, PER - 2);           // would wake if halt had been taken
    do_op(OP_IDLE, 1);
    check_all(9, 1'b1, 1'b0, 1'b1, 1'b0);

    // R1: power-on in mid-run clears flags and halt, count restarts
    do_op(OP_CLR, 0);
    do_op(OP_HALT, 0);
    @(negedge clk); por = 1'b1;
    #1;
    check_all(1, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk); por = 1'b0;
    do_op(OP_IDLE, PER - 1);
    check_all(1, 1'b0, 1'b0, 1'b0, 1'b0);
    do_op(OP_IDLE, 1);
    check_all(1, 1'b1, 1'b0, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule